// File: doc/BRIEF.md
# Serial Frame Receive Front End

This block sits between a serial line decoder and a receive engine that works on bytes. On each rising edge of the receive clock it takes one data bit, but only while carrier sense is high. After carrier rises it looks through the preamble for two 1 bits in a row. Once it has found them, it packs the bits that follow into bytes, least significant bit first, and presents each byte with a one-cycle strobe.

When carrier sense has been low for two samples in a row, the frame is over. The block then raises an end-of-frame pulse and drops any bits left over that do not fill a byte. If five or fewer bits are left over, the frame is reported as aligned. If six or seven are left over, an alignment error is reported with the pulse. A fixed number of clocks after carrier fell, a done pulse tells the engine that end-of-receive processing is finished, and the block returns to idle.

A single low sample of carrier sense is treated as a glitch. If carrier is lost before synch is found, the block goes back to idle and reports nothing.

Top module: `serial_rx_front`

## Requirements
- R1: `ser_din` is sampled on the rising clock edge. Data bits go into a byte least significant bit first: the first bit after synch becomes bit 0. `byte_valid` is high for exactly one cycle, in the cycle after the edge that samples the eighth bit, and `byte_data` carries that byte.
- R2: While hunting, the first two consecutive samples of 1 (both taken with carrier high) form the synch point. The bit sampled on the next edge becomes data bit 0.
- R3: The first sample with carrier high is bit index 0. A synch pair whose second 1 has an index below `MIN_PRE` (8) is ignored and hunting continues. A pair whose second 1 is at index 8 is accepted.
- R4: A single sample of carrier low, followed by a high sample, takes no bit and does not end the frame.
- R5: Two consecutive low carrier samples during data end the frame. `eof` is high for one cycle, in the cycle after the edge that samples the second low.
- R6: If 0 to `MAX_DRIBBLE` (5) bits are left over at end of frame, no byte is produced for them and `align_err` stays low with `eof`.
- R7: If 6 or 7 bits are left over, `align_err` is high in the same cycle as `eof`. It is never high at any other time.
- R8: `done` is high for one cycle, in the cycle after the edge that comes `RECOVERY` (5) edges after the first low carrier sample. The block is then idle and ready for a new frame.
- R9: If carrier is lost (two low samples) before synch, the block returns to idle and produces no byte, no `eof` and no `done`.
- R10: While `rst_n` is low at a clock edge, all outputs are cleared and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; bits are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_in | input | 1 | Carrier sense from the decoder |
| ser_din | input | 1 | Serial receive data |
| byte_data | output | 8 | Assembled byte, valid with `byte_valid` |
| byte_valid | output | 1 | One-cycle strobe for each completed byte |
| eof | output | 1 | One-cycle end-of-frame pulse |
| align_err | output | 1 | Alignment error, high only together with `eof` |
| done | output | 1 | One-cycle pulse when end-of-receive processing is complete |

## Verification
The driver numbers every clock edge it drives a sample on. It records the edge that samples each eighth data bit as the due cycle of that byte, and the edge that samples the second low carrier as the due cycle of `eof`. The due cycle of `done` is the first low-carrier edge plus five. The monitor samples on the falling edge, so its cycle count equals the number of the last rising edge. Each strobe that appears is popped from the scoreboard, and its kind, value and cycle number are compared, so an early or late strobe fails just as a wrong value does. A strobe that appears while the queue is empty, such as a byte from a frame lost during hunting, is reported as unexpected.

// File: rtl/rxfe_pkg.sv
package rxfe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_DATA = 2'd2,
    ST_TAIL = 2'd3
  } rxfe_state_t;

  // Leftover bit count at end of carrier beyond the tolerated limit.
  function automatic logic dribble_bad(input int unsigned fill, input int unsigned limit);
    return fill > limit;
  endfunction

  // Next shift register value when a new bit enters at the top (LSB-first assembly).
  function automatic logic [7:0] lsb_first_shift(input logic [7:0] cur, input logic bit_in);
    return {bit_in, cur[7:1]};
  endfunction

endpackage

// File: rtl/rxfe_carrier_qual.sv
module rxfe_carrier_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_in,
  output logic bit_take,
  output logic carrier_end
);
  logic low_q;

  always_ff @(posedge clk) begin
    if (!rst_n) low_q <= 1'b0;
    else        low_q <= ~carrier_in;
  end

  assign bit_take    = carrier_in;
  assign carrier_end = ~carrier_in & low_q;
endmodule

// File: rtl/rxfe_synch_det.sv
module rxfe_synch_det #(
  parameter int MIN_PRE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic hunt_take,
  input  logic ser_din,
  output logic synch_hit
);
  localparam int CW = $clog2(MIN_PRE + 1);

  logic          prev_one;
  logic [CW-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_one <= 1'b0;
      idx      <= '0;
    end else if (arm) begin
      prev_one <= ser_din;
      idx      <= CW'(1);
    end else if (hunt_take) begin
      prev_one <= ser_din;
      if (idx < CW'(MIN_PRE)) idx <= idx + CW'(1);
    end
  end

  assign synch_hit = hunt_take & ser_din & prev_one & (idx >= CW'(MIN_PRE));
endmodule

// File: rtl/rxfe_deser.sv
module rxfe_deser #(
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       shift,
  input  logic                       ser_din,
  output logic                       byte_done,
  output logic [BYTE_W-1:0]          byte_next,
  output logic [$clog2(BYTE_W)-1:0]  fill
);
  import rxfe_pkg::*;
  localparam int BCW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sr;
  logic [BCW-1:0]    cnt;

  assign byte_next = lsb_first_shift(sr, ser_din);
  assign byte_done = shift & (cnt == BCW'(BYTE_W - 1));
  assign fill      = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (shift) begin
      sr  <= byte_next;
      cnt <= byte_done ? '0 : cnt + BCW'(1);
    end
  end
endmodule

// File: rtl/rxfe_tail_timer.sv
module rxfe_tail_timer #(
  parameter int RECOVERY = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expire
);
  localparam int TW = $clog2(RECOVERY + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= TW'(1);
    else if (run)   cnt <= cnt + TW'(1);
  end

  assign expire = run & (cnt == TW'(RECOVERY - 1));
endmodule

// File: rtl/serial_rx_front.sv
module serial_rx_front #(
  parameter int MIN_PRE     = 8,
  parameter int MAX_DRIBBLE = 5,
  parameter int RECOVERY    = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       carrier_in,
  input  logic       ser_din,
  output logic [7:0] byte_data,
  output logic       byte_valid,
  output logic       eof,
  output logic       align_err,
  output logic       done
);
  import rxfe_pkg::*;
  localparam int BYTE_W = 8;
  localparam int BCW    = $clog2(BYTE_W);

  rxfe_state_t state;

  // named internal events
  logic bit_take, carrier_end, synch_hit, byte_done, tail_expire;
  logic arm_w, hunt_take_w, shift_w, tail_start_w, tail_run_w;
  logic [BYTE_W-1:0] byte_next;
  logic [BCW-1:0]    fill;

  assign arm_w        = (state == ST_IDLE) & carrier_in;
  assign hunt_take_w  = (state == ST_HUNT) & bit_take;
  assign shift_w      = (state == ST_DATA) & bit_take;
  assign tail_start_w = (state == ST_DATA) & carrier_end;
  assign tail_run_w   = (state == ST_TAIL);

  rxfe_carrier_qual u_cq (
    .clk(clk), .rst_n(rst_n), .carrier_in(carrier_in),
    .bit_take(bit_take), .carrier_end(carrier_end)
  );

  rxfe_synch_det #(.MIN_PRE(MIN_PRE)) u_sd (
    .clk(clk), .rst_n(rst_n), .arm(arm_w), .hunt_take(hunt_take_w),
    .ser_din(ser_din), .synch_hit(synch_hit)
  );

  rxfe_deser #(.BYTE_W(BYTE_W)) u_ds (
    .clk(clk), .rst_n(rst_n), .clear(synch_hit), .shift(shift_w),
    .ser_din(ser_din), .byte_done(byte_done), .byte_next(byte_next), .fill(fill)
  );

  rxfe_tail_timer #(.RECOVERY(RECOVERY)) u_tt (
    .clk(clk), .rst_n(rst_n), .start(tail_start_w), .run(tail_run_w),
    .expire(tail_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      byte_data  <= '0;
      byte_valid <= 1'b0;
      eof        <= 1'b0;
      align_err  <= 1'b0;
      done       <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      eof        <= 1'b0;
      align_err  <= 1'b0;
      done       <= 1'b0;
      case (state)
        ST_IDLE: if (carrier_in) state <= ST_HUNT;
        ST_HUNT: begin
          if (synch_hit)        state <= ST_DATA;
          else if (carrier_end) state <= ST_IDLE;
        end
        ST_DATA: begin
          if (carrier_end) begin
            state     <= ST_TAIL;
            eof       <= 1'b1;
            align_err <= dribble_bad(32'(fill), MAX_DRIBBLE);
          end else if (byte_done) begin
            byte_valid <= 1'b1;
            byte_data  <= byte_next;
          end
        end
        ST_TAIL: begin
          if (tail_expire) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R5
  eof_two_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> ($past(!carrier_in, 1) && $past(!carrier_in, 2)));

  // R7
  align_with_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> eof);

  // R9
  hunt_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT) |-> (!byte_valid && !eof && !done));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!eof && state == ST_IDLE));
endmodule

// File: tb/serial_rx_front_tb_top.sv
module serial_rx_front_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic carrier_in = 1'b0;
  logic ser_din = 1'b0;
  logic [7:0] byte_data;
  logic byte_valid, eof, align_err, done;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  typedef struct {
    int kind;   // 0 byte, 1 eof, 2 done
    int data;   // byte value or align flag
    int due;
  } ev_t;
  ev_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_rx_front dut_i (
    .clk(clk), .rst_n(rst_n), .carrier_in(carrier_in), .ser_din(ser_din),
    .byte_data(byte_data), .byte_valid(byte_valid), .eof(eof),
    .align_err(align_err), .done(done)
  );

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic drive(input logic c, input logic d, output int edge_no);
    @(negedge clk);
    carrier_in = c;
    ser_din    = d;
    edge_no    = cyc + 1;
    @(posedge clk);
  endtask

  function automatic string kind_req(input int k);
    return (k == 0) ? "R1" : (k == 1) ? "R5" : "R8";
  endfunction

  task automatic pop_cmp(input int kind, input int val);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, (kind == 0) ? "R9 unexpected byte" : "R9 unexpected end event", kind, -1);
      return;
    end
    e = exp_q.pop_front();
    chk(e.kind == kind, {kind_req(e.kind), " kind"}, kind, e.kind);
    chk(e.due == cyc, {kind_req(e.kind), " timing"}, cyc, e.due);
    if (kind == 0) chk(val == e.data, "R1 R2 R3 R4 byte value", val, e.data);
    if (kind == 1) chk(val == e.data, "R6 R7 align_err", val, e.data);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid) pop_cmp(0, int'(byte_data));
      if (eof) pop_cmp(1, int'(align_err));
      if (done) pop_cmp(2, 0);
      if (align_err && !eof) chk(1'b0, "R7 align_err without eof", 1, 0);
    end
  end

  // pre: preamble bits LSB first; payload bit b is data bit b; glitch_pos: data bit preceded by a single low sample
  task automatic run_frame(input logic [31:0] pre, input int plen,
                           input logic [31:0] payload, input int nbytes,
                           input int ndrib, input int glitch_pos);
    int e;
    int f;
    ev_t x;
    for (int i = 0; i < plen; i++) drive(1'b1, pre[i], e);
    for (int b = 0; b < nbytes * 8; b++) begin
      if (b == glitch_pos) drive(1'b0, 1'b1, e);
      drive(1'b1, payload[b], e);
      if (b % 8 == 7) begin
        x.kind = 0; x.data = int'(payload[b-7 +: 8]); x.due = e;
        exp_q.push_back(x);
      end
    end
    for (int d = 0; d < ndrib; d++) drive(1'b1, d[0], e);
    drive(1'b0, 1'b0, f);
    drive(1'b0, 1'b0, e);
    x.kind = 1; x.data = (ndrib >= 6) ? 1 : 0; x.due = e;
    exp_q.push_back(x);
    x.kind = 2; x.data = 0; x.due = f + 5;
    exp_q.push_back(x);
    for (int k = 0; k < 6; k++) drive(1'b0, 1'b0, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(byte_valid == 1'b0, "R10 byte_valid", int'(byte_valid), 0);
    chk(eof == 1'b0, "R10 eof", int'(eof), 0);
    chk(align_err == 1'b0, "R10 align_err", int'(align_err), 0);
    chk(done == 1'b0, "R10 done", int'(done), 0);
    chk(byte_data == 8'h00, "R10 byte_data", int'(byte_data), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1 R2: standard preamble, synch at index 9, two bytes, no dribble
    run_frame(32'h355, 10, 32'h0000_C3A5, 2, 0, -1);
    // R3: early pair at index 1 ignored, synch at index 10
    run_frame(32'h6AB, 11, 32'h0000_5A1E, 2, 3, -1);
    // R3: pair ending at index 7 ignored, later pair at index 10 used
    run_frame(32'h6D5, 11, 32'h0000_0081, 1, 5, -1);
    // R3: pair ending exactly at index 8 accepted
    run_frame(32'h195, 9, 32'h00FF_7E01, 3, 0, -1);
    // R6 R7: six and seven leftover bits flag alignment error
    run_frame(32'h355, 10, 32'h0000_0042, 1, 6, -1);
    run_frame(32'h355, 10, 32'h0000_00BD, 1, 7, -1);
    // R4: single-sample carrier glitch inside data
    run_frame(32'h355, 10, 32'hDEAD_BEEF, 4, 2, 13);
    // R4: glitch right before the first data bit of the second byte
    run_frame(32'h355, 10, 32'h0000_3C96, 2, 1, 8);

    // R9: carrier lost during hunt, nothing expected
    drive(1'b1, 1'b1, e);
    drive(1'b1, 1'b0, e);
    drive(1'b1, 1'b1, e);
    drive(1'b1, 1'b0, e);
    for (int k = 0; k < 8; k++) drive(1'b0, 1'b0, e);
    // R8: block is idle again and receives a normal frame
    run_frame(32'h355, 10, 32'h0000_0077, 1, 4, -1);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R1 R5 R8 missing events", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule